// File: doc/BRIEF.md
# Serial Successive-Approximation Sequencer

This block is the digital control core of an 8-bit serial successive-approximation converter with two analog inputs. It runs on a fast system clock. It oversamples a chip-select, a serial clock and a serial data-in line, all of which must already be synchronous to that system clock. Once the block is armed by chip-select going low, it hunts for a start bit on the data-in line. It then takes a two-bit word that selects how the input multiplexer is connected. After that it performs a bit-by-bit binary search against an external resistor ladder.

The ladder sees the `trial_code` output, and the comparator answers on `cmp_below`. Each decided bit appears on the serial data output as soon as it is known, most significant bit first. The finished result is then repeated least significant bit first. The serial output is a data bit plus an output enable, so the pad can be tri-stated outside the block. Raising chip-select clears everything at any point in a frame.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is high, and one system clock after it is sampled high, `dout_oe`, `mux_valid` and `trial_code` are all zero, and serial clock edges have no effect.
- R2: After `cs_n` falls, `din` is sampled on each serial clock rise. Low bits are skipped and the first high bit is taken as the start bit; nothing is driven while the block hunts for it.
- R3: The two bits after the start bit are the mode bit (1 = single-ended, 0 = differential) and then the select bit. On the rise that samples the select bit, `mux_valid` goes to 1, `mux_pos_ch1` takes the select bit (0 = channel 0 positive, 1 = channel 1 positive) and `mux_diff` takes the inverse of the mode bit (1 = the other channel is the negative input).
- R4: For exactly one serial clock period after addressing, `dout_oe` is 1 and `dout` is 0.
- R5: During conversion, `trial_code` holds the bits already decided plus a 1 in the bit under test, starting at 0x80. On each serial rise the bit under test is kept when `cmp_below` is 0 and cleared when it is 1. `trial_code` returns to 0 after bit 0 is decided.
- R6: The k-th serial rise after the settling period puts result bit 8-k on `dout` (MSB first).
- R7: When the negative input is above the positive input, `cmp_below` is always 1, the result is 0x00, and `dout` stays low for the whole frame.
- R8: After bit 0, the next seven rises put result bits 1 through 7 on `dout`. The rise after that sets `dout_oe` to 0, and it stays 0 until `cs_n` rises.
- R9: `din` has no effect from the end of addressing until `cs_n` rises. The multiplexer outputs hold their values for the rest of the frame.
- R10: Raising `cs_n` in the middle of a conversion aborts it within one system clock. A following frame that starts with a new falling `cs_n` converts correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high clears the frame |
| sclk | input | 1 | Serial clock, acted on at its rising edge |
| din | input | 1 | Serial start, mode and select bits |
| cmp_below | input | 1 | Comparator: 1 when the analog input is below the ladder |
| trial_code | output | 8 | Code presented to the resistor ladder |
| mux_valid | output | 1 | Multiplexer selection is valid |
| mux_pos_ch1 | output | 1 | 1 = channel 1 is the positive input |
| mux_diff | output | 1 | 1 = differential, the other channel is negative |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable for dout; 0 means high impedance |

## Verification
Every result of a serial rise becomes visible one system clock after the first system edge that samples `sclk` high. This covers the multiplexer outputs, the settling low, each decided bit, the next trial code, each LSB-first bit and the release of the output. The bench raises `sclk` at a falling system edge and samples all outputs at the next falling edge, while `sclk` is still high and well before the next rise. Clearing through `cs_n` is due one system clock after `cs_n` is sampled high, so the abort check samples one falling edge after raising it. The comparator answer is computed from `trial_code` by an analog model in the bench, so it is always settled before the next rise.

// File: rtl/sar_seq_pkg.sv
// Shared types of the serial successive-approximation sequencer.
package sar_seq_pkg;

    // Frame phases, in the order a frame passes through them.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // deselected or not yet armed
        ST_HUNT = 3'd1,   // waiting for the start bit
        ST_ADDR = 3'd2,   // taking the mode and select bits
        ST_CONV = 3'd3,   // settling period, then one decision per rise
        ST_TAIL = 3'd4,   // repeating the result LSB first
        ST_DONE = 3'd5    // output released, waiting for deselect
    } frame_state_e;

endpackage

// File: rtl/sar_edge_detect.sv
// Edge detector for a level already synchronous to clk.
// Gives a one-cycle pulse on the chosen edge. Assumes the input is glitch-free
// and stable for at least one clk period around each transition.
module sar_edge_detect #(
    parameter bit FALLING = 1'b0,   // 0: rising edge, 1: falling edge
    parameter bit RST_VAL = 1'b0    // assumed previous level after reset
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic prev_q;

    // Keep the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = prev_q & ~level;
        end else begin : g_rise
            assign pulse = level & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/sar_frame_ctrl.sv
// Frame sequencer: it arms on the select edge, hunts for the start bit, counts
// the two address bits, steps the conversion bits downward and then the
// LSB-first repeat upward. All of its outputs are strobes qualified by a
// serial-clock rise. A high clr (chip select released) returns it to idle.
module sar_frame_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES = 8,
    localparam int CNT_W = $clog2(RES + 1),
    localparam int IDX_W = (RES > 1) ? $clog2(RES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm,
    input  logic             step,
    input  logic             din,
    output logic             addr_shift,
    output logic             conv_start,
    output logic             decide,
    output logic             conv_last,
    output logic             tail_load,
    output logic             finish,
    output logic [IDX_W-1:0] bit_idx
);
    localparam logic [CNT_W-1:0] TOP_BIT  = CNT_W'(RES - 1);
    localparam logic [CNT_W-1:0] TAIL_END = CNT_W'(RES);

    frame_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             addr_cnt_q;

    // Strobes decoded from the current phase and the serial rise.
    assign addr_shift = step && (state_q == ST_ADDR);
    assign conv_start = addr_shift && addr_cnt_q;
    assign decide     = step && (state_q == ST_CONV);
    assign conv_last  = decide && (cnt_q == '0);
    assign tail_load  = step && (state_q == ST_TAIL) && (cnt_q != TAIL_END);
    assign finish     = step && (state_q == ST_TAIL) && (cnt_q == TAIL_END);
    assign bit_idx    = cnt_q[IDX_W-1:0];

    // Phase register, bit counter and address bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            addr_cnt_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (arm) state_q <= ST_HUNT;
                ST_HUNT: begin
                    if (step && din) begin
                        state_q    <= ST_ADDR;
                        addr_cnt_q <= 1'b0;
                    end
                end
                ST_ADDR: begin
                    if (step) begin
                        addr_cnt_q <= 1'b1;
                        if (addr_cnt_q) begin
                            state_q <= ST_CONV;
                            cnt_q   <= TOP_BIT;
                        end
                    end
                end
                ST_CONV: begin
                    if (step) begin
                        if (cnt_q == '0) begin
                            state_q <= ST_TAIL;
                            cnt_q   <= CNT_W'(1);
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (step) begin
                        if (cnt_q == TAIL_END) state_q <= ST_DONE;
                        else                   cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end
endmodule

// File: rtl/sar_addr_decode.sv
// Multiplexer address decoder. The first address bit is the mode bit
// (1 = single-ended) and the second is the select bit (which channel is
// positive). The selection is presented from the last address bit until clr.
module sar_addr_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift,
    input  logic latch,
    input  logic din,
    output logic mux_valid,
    output logic mux_pos_ch1,
    output logic mux_diff
);
    logic mode_q;

    // Hold the mode bit, then present the full selection when the select bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mode_q      <= 1'b0;
            mux_valid   <= 1'b0;
            mux_pos_ch1 <= 1'b0;
            mux_diff    <= 1'b0;
        end else if (latch) begin
            mux_valid   <= 1'b1;
            mux_pos_ch1 <= din;
            mux_diff    <= ~mode_q;
        end else if (shift) begin
            mode_q <= din;
        end
    end
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register. It presents the decided bits plus the
// bit under test to the ladder, and on each decide strobe keeps that bit
// unless the comparator reports the input below the ladder.
module sar_approx #(
    parameter int RES = 8,
    localparam int IDX_W = (RES > 1) ? $clog2(RES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             decide,
    input  logic             last,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_below,
    output logic             decision,
    output logic [RES-1:0]   result,
    output logic [RES-1:0]   trial_code
);
    logic           active_q;
    logic [RES-1:0] probe;

    assign decision = ~cmp_below;
    assign probe    = {{(RES-1){1'b0}}, 1'b1} << bit_idx;
    // Ladder code: only while a search is running.
    assign trial_code = active_q ? (result | probe) : '0;

    // Decided bits and the running flag of the search.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            result   <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            result   <= '0;
            active_q <= 1'b1;
        end else if (decide) begin
            result[bit_idx] <= decision;
            if (last) active_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_dout_drive.sv
// Serial output stage. It drives low during settling, shows each decision
// as it is made, replays the result LSB first and then releases the line.
// The line is high impedance outside that window (dout_oe = 0).
module sar_dout_drive #(
    parameter int RES = 8,
    localparam int IDX_W = (RES > 1) ? $clog2(RES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             decide,
    input  logic             decision,
    input  logic             tail_load,
    input  logic             finish,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [RES-1:0]   result,
    output logic             dout,
    output logic             dout_oe
);
    // Output bit and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || finish) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (start) begin
            dout    <= 1'b0;
            dout_oe <= 1'b1;
        end else if (decide) begin
            dout <= decision;
        end else if (tail_load) begin
            dout <= result[bit_idx];
        end
    end
endmodule

// File: rtl/sar_serial_seq.sv
// Top of the serial successive-approximation sequencer. It assumes cs_n,
// sclk and din are synchronous to clk and that each sclk level lasts at
// least two clk periods. A high cs_n clears the whole block synchronously.
module sar_serial_seq #(
    parameter int RES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic           din,
    input  logic           cmp_below,
    output logic [RES-1:0] trial_code,
    output logic           mux_valid,
    output logic           mux_pos_ch1,
    output logic           mux_diff,
    output logic           dout,
    output logic           dout_oe
);
    localparam int IDX_W = (RES > 1) ? $clog2(RES) : 1;

    logic             arm, step;
    logic             addr_shift, conv_start, decide, conv_last;
    logic             tail_load, finish, decision;
    logic [IDX_W-1:0] bit_idx;
    logic [RES-1:0]   result;

    sar_edge_detect #(.FALLING(1'b1), .RST_VAL(1'b0)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .level(cs_n), .pulse(arm)
    );

    sar_edge_detect #(.FALLING(1'b0), .RST_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .level(sclk), .pulse(step)
    );

    sar_frame_ctrl #(.RES(RES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(cs_n), .arm(arm), .step(step),
        .din(din), .addr_shift(addr_shift), .conv_start(conv_start),
        .decide(decide), .conv_last(conv_last), .tail_load(tail_load),
        .finish(finish), .bit_idx(bit_idx)
    );

    sar_addr_decode u_addr (
        .clk(clk), .rst_n(rst_n), .clr(cs_n), .shift(addr_shift),
        .latch(conv_start), .din(din), .mux_valid(mux_valid),
        .mux_pos_ch1(mux_pos_ch1), .mux_diff(mux_diff)
    );

    sar_approx #(.RES(RES)) u_sar (
        .clk(clk), .rst_n(rst_n), .clr(cs_n), .start(conv_start),
        .decide(decide), .last(conv_last), .bit_idx(bit_idx),
        .cmp_below(cmp_below), .decision(decision), .result(result),
        .trial_code(trial_code)
    );

    sar_dout_drive #(.RES(RES)) u_out (
        .clk(clk), .rst_n(rst_n), .clr(cs_n), .start(conv_start),
        .decide(decide), .decision(decision), .tail_load(tail_load),
        .finish(finish), .bit_idx(bit_idx), .result(result),
        .dout(dout), .dout_oe(dout_oe)
    );
endmodule

// File: rtl/sar_serial_seq_chk.sv
// Property checker for the sequencer, attached through bind. It only observes
// ports of the top module.
module sar_serial_seq_chk #(
    parameter int RES = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic [RES-1:0] trial_code,
    input logic           mux_valid,
    input logic           mux_pos_ch1,
    input logic           mux_diff,
    input logic           dout,
    input logic           dout_oe
);
    // R1
    deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_oe && !mux_valid && trial_code == '0));

    // R4
    settle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout);

    // R3
    mux_with_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mux_valid) |-> (dout_oe && !dout));

    // R9
    mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && mux_valid) |=> (mux_valid && $stable(mux_pos_ch1) && $stable(mux_diff)));

    // R5
    trial_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_code != '0) |-> (dout_oe && mux_valid));

    // R8
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dout_oe) && !cs_n) |-> (trial_code == '0 && mux_valid));
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.RES(RES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .trial_code(trial_code),
    .mux_valid(mux_valid), .mux_pos_ch1(mux_pos_ch1), .mux_diff(mux_diff),
    .dout(dout), .dout_oe(dout_oe)
);

// File: tb/tb_sar_serial_seq.sv
// Bench for sar_serial_seq: directed corner frames plus seeded random frames.
module tb_sar_serial_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       cmp_below;
    logic [7:0] trial_code;
    logic       mux_valid, mux_pos_ch1, mux_diff, dout, dout_oe;

    logic [7:0] ana_val = 8'h00;
    logic       neg_win = 1'b0;

    int checks = 0;
    int errors = 0;

    logic       s_oe, s_dout, s_mv, s_pos, s_diff;
    logic [7:0] s_trial;

    always #10 clk = ~clk;

    // Analog model: the input sits at ana_val, or below zero when the negative input wins.
    assign cmp_below = neg_win ? 1'b1 : (trial_code > ana_val);

    sar_serial_seq #(.RES(8)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cmp_below(cmp_below), .trial_code(trial_code), .mux_valid(mux_valid),
        .mux_pos_ch1(mux_pos_ch1), .mux_diff(mux_diff), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One serial clock period; outputs are sampled one clk after the rise.
    task automatic tick(input logic d);
        @(negedge clk); din = d; sclk = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        @(negedge clk);
        s_oe = dout_oe; s_dout = dout; s_mv = mux_valid;
        s_pos = mux_pos_ch1; s_diff = mux_diff; s_trial = trial_code;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] trial_after(input logic [7:0] res, input int k);
        logic [7:0] keep;
        if (k == 0) return 8'h00;
        keep = res & (8'hFF << k);
        return keep | (8'h01 << (k - 1));
    endfunction

    task automatic run_frame(input int nz, input bit sgl, input bit odd,
                             input logic [7:0] ana, input bit negw, input bit noisy);
        logic [7:0] exp;
        exp = negw ? 8'h00 : ana;
        ana_val = ana; neg_win = negw;
        @(negedge clk); cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
        repeat (3) @(negedge clk);
        chk(!dout_oe && !mux_valid && trial_code == 8'h00, "R1 deselected idle",
            {dout_oe, mux_valid}, 0);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nz; i++) begin
            tick(1'b0);
            chk(!s_oe && !s_mv, "R2 leading low skipped", {s_oe, s_mv}, 0);
        end
        tick(1'b1);
        chk(!s_oe && !s_mv, "R2 start bit, nothing driven", {s_oe, s_mv}, 0);
        tick(sgl);
        chk(!s_oe && !s_mv, "R2 mode bit, nothing driven", {s_oe, s_mv}, 0);
        tick(odd);
        chk(s_mv && s_pos == odd && s_diff == !sgl, "R3 mux select",
            {s_mv, s_pos, s_diff}, {1'b1, odd, !sgl});
        chk(s_oe && !s_dout, "R4 settle low", {s_oe, s_dout}, 2);
        chk(s_trial == 8'h80, "R5 first trial", s_trial, 8'h80);
        for (int k = 7; k >= 0; k--) begin
            tick(noisy ? 1'($urandom % 2) : 1'b0);
            chk(s_oe && s_dout == exp[k], negw ? "R7 stays low" : "R6 msb-first bit",
                {s_oe, s_dout}, {1'b1, exp[k]});
            chk(s_trial == trial_after(exp, k), "R5 trial step", s_trial, trial_after(exp, k));
            chk(s_mv && s_pos == odd && s_diff == !sgl, "R9 mux held, din ignored",
                {s_mv, s_pos, s_diff}, {1'b1, odd, !sgl});
        end
        for (int j = 1; j < 8; j++) begin
            tick(noisy ? 1'($urandom % 2) : 1'b1);
            chk(s_oe && s_dout == exp[j], "R8 lsb-first bit", {s_oe, s_dout}, {1'b1, exp[j]});
        end
        tick(1'b0);
        chk(!s_oe, "R8 release", s_oe, 0);
        tick(1'b1);
        chk(!s_oe && s_trial == 8'h00 && s_mv, "R9 din ignored after release",
            {s_oe, s_trial}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd8675309));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dout_oe && !mux_valid && trial_code == 8'h00 && !dout, "R1 reset state",
            {dout_oe, mux_valid, dout}, 0);

        // R1: serial clocks with din high while deselected do nothing.
        for (int i = 0; i < 4; i++) begin
            tick(1'b1);
            chk(!s_oe && !s_mv && s_trial == 8'h00, "R1 clocks ignored while deselected",
                {s_oe, s_mv}, 0);
        end

        run_frame(0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0);
        run_frame(3, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1);
        run_frame(1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        run_frame(2, 1'b0, 1'b0, 8'h9C, 1'b1, 1'b1);   // R7 negative input wins
        run_frame(0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0);
        run_frame(0, 1'b1, 1'b0, 8'h7F, 1'b0, 1'b1);

        // R10: abort mid-conversion, then a clean frame.
        @(negedge clk); cs_n = 1'b1; repeat (3) @(negedge clk);
        ana_val = 8'h3C; neg_win = 1'b0;
        cs_n = 1'b0; repeat (2) @(negedge clk);
        tick(1'b1); tick(1'b1); tick(1'b0);
        tick(1'b0); tick(1'b0); tick(1'b0);
        chk(s_oe && s_mv, "R10 conversion running before abort", {s_oe, s_mv}, 3);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        chk(!dout_oe && !mux_valid && trial_code == 8'h00, "R10 abort clears",
            {dout_oe, mux_valid, trial_code}, 0);
        run_frame(1, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0);    // R10 recovery

        for (int f = 0; f < 20; f++) begin
            run_frame(int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                      8'($urandom % 256), ($urandom % 6) == 0, 1'b1);
        end

        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule